// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a fast input clock by a ratio whose long-run average is INT + FRAC/MOD. It sits in the feedback path of a fractional-N frequency synthesizer. Every time the divided output fires, a third-order interpolator built from three cascaded modulo-MOD accumulators produces a small signed offset. That offset is added to INT, and the sum becomes the length of the next divide interval. Over time the integer intervals dither around the fractional target.

The block produces a one-cycle divided pulse, meant for a phase detector, and reports the length of the interval that starts with that pulse. The divider settings are written through three value ports and a load strobe. They are held in a staging register and only take effect at an output pulse, so a count that is already running is never disturbed.

Top module: `frac_div_top`

## Requirements
- R1: A synchronous active-high reset clears all interpolator state, holds `div_pulse` low and sets `div_value` to the `int_in` value. The first pulse after reset is released arrives exactly `int_in` clock cycles later.
- R2: `div_pulse` is high for a single cycle per event. The distance in clock cycles from one pulse to the next equals the `div_value` shown together with the first of the two pulses.
- R3: At each pulse, `div_value` = INT + c1 + (c2 − c2') + (c3 − 2·c3' + c3''). The carries come from three cascaded accumulators, each of which adds its input and wraps modulo MOD:
  - a1 += FRAC, a2 += new a1, a3 += new a2.
  - ck is 1 when accumulator k wraps.
  - A prime means the value of that carry at the previous step.
  - All accumulators and carry history start at zero.
- R4: At each pulse, `div_value` lies between INT−3 and INT+4, and it is never below 2.
- R5: With FRAC = 0, every interval is exactly INT cycles long.
- R6: With constant settings, the sum of any MOD consecutive `div_value` outputs differs from MOD·INT + FRAC by at most 3.
- R7: A `load` pulse stages all three values. The staged values take effect at the first output pulse after the load edge, and the interval in progress keeps its length. When they take effect, the interpolator restarts from the all-zero state.
- R8: Changes on `int_in`, `frac_in` or `mod_in` without `load` have no effect on the output.
- R9: When two loads occur before the same pulse, the later set of values is the one applied.
- R10: `div_value` changes only on cycles where `div_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| int_in | input | INT_W (9) | Integer part of the ratio, valid 31..511 |
| frac_in | input | MOD_W (12) | Fractional numerator, valid 0..MOD−1 |
| mod_in | input | MOD_W (12) | Fractional modulus, valid 2..4095 |
| load | input | 1 | Strobe that stages the three values |
| div_pulse | output | 1 | One-cycle divided output event |
| div_value | output | INT_W+1 (10) | Length of the interval starting at this pulse |

## Verification
`div_pulse` and the matching `div_value` are registered. They appear on the same edge that ends the previous interval, so the next pulse is due exactly `div_value` cycles after the current one. The first pulse after reset release is due `int_in` cycles after release. A load applies to the pulse following the edge that captures it. The bench counts rising edges and samples outputs on falling edges. At each pulse it compares the measured spacing against the previously reported length, and it pops the expected length from a scoreboard queue. The driver only issues a load after the queue for the previous settings has drained, which pins each settings change to a known pulse.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  // Interpolator order: three cascaded accumulators.
  localparam int ORDER = 3;
  // Signed offset width: the offset spans -3..+4.
  localparam int OFS_W = 4;
  // Smallest interval length the counter accepts.
  localparam int N_MIN = 2;

  typedef logic signed [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/frac_div_cfg.sv
module frac_div_cfg #(
  parameter int INT_W = 9,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] int_in,
  input  logic [MOD_W-1:0] frac_in,
  input  logic [MOD_W-1:0] mod_in,
  input  logic             load,
  input  logic             boundary,
  output logic [INT_W-1:0] eff_int,
  output logic [MOD_W-1:0] eff_frac,
  output logic [MOD_W-1:0] eff_mod,
  output logic             restart,
  output logic [INT_W-1:0] act_int,
  output logic [MOD_W-1:0] act_frac
);
  logic [INT_W-1:0] stg_int;
  logic [MOD_W-1:0] stg_frac, stg_mod, act_mod;
  logic             stg_vld;

  // Staged values win at a boundary; otherwise the active set is used.
  assign eff_int  = stg_vld ? stg_int  : act_int;
  assign eff_frac = stg_vld ? stg_frac : act_frac;
  assign eff_mod  = stg_vld ? stg_mod  : act_mod;
  assign restart  = stg_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_int  <= int_in;
      act_frac <= frac_in;
      act_mod  <= mod_in;
      stg_int  <= '0;
      stg_frac <= '0;
      stg_mod  <= '0;
      stg_vld  <= 1'b0;
    end else begin
      if (boundary) begin
        act_int  <= eff_int;
        act_frac <= eff_frac;
        act_mod  <= eff_mod;
      end
      if (load) begin
        stg_int  <= int_in;
        stg_frac <= frac_in;
        stg_mod  <= mod_in;
        stg_vld  <= 1'b1;
      end else if (boundary) begin
        stg_vld  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frac_div_mash.sv
module frac_div_mash
  import frac_div_pkg::*;
#(
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             restart,
  input  logic [MOD_W-1:0] frac,
  input  logic [MOD_W-1:0] modulus,
  output ofs_t             ofs
);
  localparam int SUM_W = MOD_W + 1;

  logic [ORDER-1:0][MOD_W-1:0] acc_q, acc_d;
  logic [ORDER-1:0]            cy;
  logic c2_h_q, c3_h_q, c3_hh_q;
  logic c2_h, c3_h, c3_hh;

  // History seen by this step: zero when a new setting restarts the cascade.
  assign c2_h  = restart ? 1'b0 : c2_h_q;
  assign c3_h  = restart ? 1'b0 : c3_h_q;
  assign c3_hh = restart ? 1'b0 : c3_hh_q;

  always_comb begin
    logic [MOD_W-1:0] feed;
    logic [MOD_W-1:0] base;
    logic [SUM_W-1:0] sum;
    feed = frac;
    for (int k = 0; k < ORDER; k++) begin
      base     = restart ? '0 : acc_q[k];
      sum      = {1'b0, base} + {1'b0, feed};
      cy[k]    = (sum >= {1'b0, modulus});
      acc_d[k] = cy[k] ? MOD_W'(sum - {1'b0, modulus}) : sum[MOD_W-1:0];
      feed     = acc_d[k];
    end
  end

  // Third-order noise-shaped combination: c1 + d(c2) + d2(c3).
  assign ofs = ofs_t'({3'b000, cy[0]})
             + ofs_t'({3'b000, cy[1]}) - ofs_t'({3'b000, c2_h})
             + ofs_t'({3'b000, cy[2]}) - ofs_t'({2'b00, c3_h, 1'b0})
             + ofs_t'({3'b000, c3_hh});

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      c2_h_q  <= 1'b0;
      c3_h_q  <= 1'b0;
      c3_hh_q <= 1'b0;
    end else if (step) begin
      acc_q   <= acc_d;
      c2_h_q  <= cy[1];
      c3_h_q  <= cy[2];
      c3_hh_q <= c3_h;
    end
  end
endmodule

// File: rtl/frac_div_cnt.sv
module frac_div_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] init_n,
  input  logic [CNT_W-1:0] next_n,
  output logic             term,
  output logic             pulse_q,
  output logic [CNT_W-1:0] n_q
);
  logic [CNT_W-1:0] cnt_q;

  // The last cycle of an interval is the boundary.
  assign term = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= init_n;
      n_q     <= init_n;
      pulse_q <= 1'b0;
    end else if (term) begin
      cnt_q   <= next_n;
      n_q     <= next_n;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - CNT_W'(1);
      pulse_q <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_div_top.sv
module frac_div_top
  import frac_div_pkg::*;
#(
  parameter int INT_W = 9,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] int_in,
  input  logic [MOD_W-1:0] frac_in,
  input  logic [MOD_W-1:0] mod_in,
  input  logic             load,
  output logic             div_pulse,
  output logic [INT_W:0]   div_value
);
  localparam int CNT_W = INT_W + 1;
  localparam int RAW_W = INT_W + 2;

  logic [INT_W-1:0] eff_int, act_int;
  logic [MOD_W-1:0] eff_frac, eff_mod, act_frac;
  logic             restart, boundary;
  ofs_t             ofs;
  logic signed [RAW_W-1:0] n_raw;
  logic [CNT_W-1:0]        n_next;

  frac_div_cfg #(.INT_W(INT_W), .MOD_W(MOD_W)) cfg_i (
    .clk(clk), .rst(rst), .int_in(int_in), .frac_in(frac_in), .mod_in(mod_in),
    .load(load), .boundary(boundary), .eff_int(eff_int), .eff_frac(eff_frac),
    .eff_mod(eff_mod), .restart(restart), .act_int(act_int), .act_frac(act_frac)
  );

  frac_div_mash #(.MOD_W(MOD_W)) mash_i (
    .clk(clk), .rst(rst), .step(boundary), .restart(restart),
    .frac(eff_frac), .modulus(eff_mod), .ofs(ofs)
  );

  // Instantaneous ratio with a floor so the counter never stalls.
  assign n_raw  = $signed({2'b00, eff_int}) + $signed({{(RAW_W-OFS_W){ofs[OFS_W-1]}}, ofs});
  assign n_next = (n_raw < $signed(RAW_W'(N_MIN))) ? CNT_W'(N_MIN) : n_raw[CNT_W-1:0];

  frac_div_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .init_n({1'b0, int_in}), .next_n(n_next),
    .term(boundary), .pulse_q(div_pulse), .n_q(div_value)
  );
endmodule

// File: rtl/frac_div_chk.sv
module frac_div_chk #(
  parameter int INT_W = 9,
  parameter int MOD_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             div_pulse,
  input logic [INT_W:0]   div_value,
  input logic [INT_W-1:0] act_int,
  input logic [MOD_W-1:0] act_frac
);
  // R2: an event lasts one cycle
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R4: interval length stays near INT
  a_r4_in_window: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> ((int'(div_value) + 3 >= int'(act_int)) && (int'(div_value) <= int'(act_int) + 4)));

  // R4: interval floor
  a_r4_floor: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (div_value >= 2));

  // R5: zero fraction divides by INT
  a_r5_integer_only: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && act_frac == '0) |-> (int'(div_value) == int'(act_int)));

  // R10: reported length moves only with a pulse
  a_r10_value_hold: assert property (@(posedge clk) disable iff (rst)
    (!$stable(div_value) && !$past(rst)) |-> div_pulse);

  // R7: settings switch only at a pulse
  a_r7_cfg_at_pulse: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_int) && !$past(rst)) |-> div_pulse);
endmodule

bind frac_div_top frac_div_chk #(.INT_W(INT_W), .MOD_W(MOD_W)) chk_i (
  .clk(clk), .rst(rst), .div_pulse(div_pulse), .div_value(div_value),
  .act_int(act_int), .act_frac(act_frac)
);

// File: tb/frac_div_top_tb_top.sv
module frac_div_top_tb_top;
  localparam int INT_W = 9;
  localparam int MOD_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [INT_W-1:0] int_in = 9'd100;
  logic [MOD_W-1:0] frac_in = '0;
  logic [MOD_W-1:0] mod_in = 12'd10;
  logic             load = 1'b0;
  logic             div_pulse;
  logic [INT_W:0]   div_value;

  frac_div_top #(.INT_W(INT_W), .MOD_W(MOD_W)) dut_i (
    .clk(clk), .rst(rst), .int_in(int_in), .frac_in(frac_in), .mod_in(mod_in),
    .load(load), .div_pulse(div_pulse), .div_value(div_value)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  bit done = 0;

  // scoreboard state
  int exp_n[$];
  int exp_i[$];
  int obs[$];
  bit running = 0;
  bit first_pulse = 0;
  int prev_cyc, prev_div, held;
  bit held_ok;

  // model state for the three-accumulator cascade
  int m_a1, m_a2, m_a3, m_c2h, m_c3h, m_c3hh;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic model_clear();
    m_a1 = 0; m_a2 = 0; m_a3 = 0; m_c2h = 0; m_c3h = 0; m_c3hh = 0;
  endtask

  // Driver: push expected interval lengths from the R3 definition.
  task automatic push_cfg(input int iv, input int fv, input int mv, input int cnt);
    for (int p = 0; p < cnt; p++) begin
      int c1, c2, c3, off, n;
      m_a1 += fv;   c1 = (m_a1 >= mv); if (c1 != 0) m_a1 -= mv;
      m_a2 += m_a1; c2 = (m_a2 >= mv); if (c2 != 0) m_a2 -= mv;
      m_a3 += m_a2; c3 = (m_a3 >= mv); if (c3 != 0) m_a3 -= mv;
      off = c1 + c2 - m_c2h + c3 - 2 * m_c3h + m_c3hh;
      m_c3hh = m_c3h; m_c3h = c3; m_c2h = c2;
      n = iv + off;
      if (n < 2) n = 2;
      exp_n.push_back(n);
      exp_i.push_back(iv);
    end
  endtask

  // Monitor: compare at each pulse, sampled away from the rising edge.
  always @(negedge clk) begin
    if (running && !rst) begin
      if (div_pulse) begin
        if (first_pulse)
          check((cyc - prev_cyc) == prev_div, "R1 first pulse spacing", cyc - prev_cyc, prev_div);
        else
          check((cyc - prev_cyc) == prev_div, "R2 pulse spacing", cyc - prev_cyc, prev_div);
        check(held_ok, "R10 value held between pulses", held_ok, 1);
        if (exp_n.size() == 0) begin
          check(1'b0, "R3 unexpected pulse", int'(div_value), -1);
        end else begin
          int en, ei;
          en = exp_n.pop_front();
          ei = exp_i.pop_front();
          check(int'(div_value) == en, "R3 divide value", int'(div_value), en);
          check(int'(div_value) >= ei - 3 && int'(div_value) <= ei + 4 && div_value >= 2,
                "R4 range", int'(div_value), ei);
        end
        obs.push_back(int'(div_value));
        prev_cyc = cyc;
        prev_div = int'(div_value);
        held = int'(div_value);
        held_ok = 1;
        first_pulse = 0;
      end else if (int'(div_value) != held) begin
        held_ok = 0;
      end
    end
  end

  task automatic wait_drained();
    while (exp_n.size() != 0) @(posedge clk);
  endtask

  task automatic check_windows(input int iv, input int fv, input int mv);
    for (int s = 0; s + mv <= obs.size(); s++) begin
      int sum, tgt;
      sum = 0;
      for (int k = 0; k < mv; k++) sum += obs[s + k];
      tgt = mv * iv + fv;
      check(sum >= tgt - 3 && sum <= tgt + 3, "R6 window sum", sum, tgt);
    end
    if (fv == 0)
      foreach (obs[k]) check(obs[k] == iv, "R5 integer-only interval", obs[k], iv);
  endtask

  task automatic reset_dut(input int iv, input int fv, input int mv, input int cnt);
    running = 0;
    @(negedge clk);
    rst = 1;
    int_in = iv[INT_W-1:0]; frac_in = fv[MOD_W-1:0]; mod_in = mv[MOD_W-1:0];
    exp_n.delete(); exp_i.delete(); obs.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(div_pulse == 1'b0, "R1 pulse low in reset", div_pulse, 0);
    check(int'(div_value) == iv, "R1 value in reset", int'(div_value), iv);
    model_clear();
    push_cfg(iv, fv, mv, cnt);
    prev_cyc = cyc; prev_div = iv; held = iv; held_ok = 1; first_pulse = 1;
    rst = 0;
    running = 1;
  endtask

  // Stage new settings once the previous expectations are consumed.
  task automatic load_cfg(input int iv, input int fv, input int mv, input int cnt, input int delay);
    wait_drained();
    check_windows(int'(dut_i.int_in) == 0 ? 0 : exp_last_i, exp_last_f, exp_last_m);
    obs.delete();
    repeat (delay) @(negedge clk);
    @(negedge clk);
    int_in = iv[INT_W-1:0]; frac_in = fv[MOD_W-1:0]; mod_in = mv[MOD_W-1:0];
    load = 1;
    model_clear();
    push_cfg(iv, fv, mv, cnt);
    @(negedge clk);
    load = 0;
    exp_last_i = iv; exp_last_f = fv; exp_last_m = mv;
  endtask

  int exp_last_i, exp_last_f, exp_last_m;

  initial begin
    reset_dut(100, 0, 10, 20);
    exp_last_i = 100; exp_last_f = 0; exp_last_m = 10;

    // R8: port changes without load leave the output alone.
    wait_drained();
    check_windows(100, 0, 10);
    obs.delete();
    @(negedge clk);
    int_in = 9'd77; frac_in = 12'd3; mod_in = 12'd5;
    push_cfg(100, 0, 10, 5);
    wait_drained();
    foreach (obs[k]) check(obs[k] == 100, "R8 unloaded ports ignored", obs[k], 100);
    obs.delete();

    // R7: new settings at the next pulse, cascade restarted.
    @(negedge clk);
    int_in = 9'd31; frac_in = 12'd5; mod_in = 12'd7;
    load = 1;
    model_clear();
    push_cfg(31, 5, 7, 21);
    @(negedge clk);
    load = 0;
    exp_last_i = 31; exp_last_f = 5; exp_last_m = 7;

    // R9: two loads in one interval, the later applies.
    wait_drained();
    check_windows(31, 5, 7);
    obs.delete();
    @(negedge clk);
    int_in = 9'd60; frac_in = 12'd1; mod_in = 12'd3;
    load = 1;
    @(negedge clk);
    int_in = 9'd50; frac_in = 12'd7; mod_in = 12'd13;
    model_clear();
    push_cfg(50, 7, 13, 39);
    @(negedge clk);
    load = 0;
    exp_last_i = 50; exp_last_f = 7; exp_last_m = 13;

    // R7: load well inside a running interval.
    load_cfg(37, 250, 257, 260, 12);
    load_cfg(511, 3, 4, 12, 0);
    load_cfg(200, 199, 200, 220, 5);
    load_cfg(64, 0, 9, 10, 3);
    wait_drained();
    check_windows(exp_last_i, exp_last_f, exp_last_m);

    // R1: a second reset restarts from the current INT.
    reset_dut(45, 1, 3, 9);
    wait_drained();
    check_windows(45, 1, 3);
    repeat (4) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule